// File: doc/BRIEF.md
# Pipeline Instruction Footprint Recorder

This block sits beside one stage of an out-of-order processor pipeline and keeps a short history of the instructions that passed through it. On every cycle the stage reports a valid instruction, the recorder writes one entry into a circular buffer. An entry holds the instruction's recycled in-flight tag and a few bits of auxiliary information chosen for that stage. There is no timestamp. The tags alone let offline software line up the histories of several stages.

Recording runs until an early-warning trigger arrives, for example from a residue checker, a parity checker or a hang detector. The buffer then freezes, so it keeps the instructions that led up to the suspected fault. After the failure, the frozen contents are shifted out one bit at a time through a slow serial path that is enabled cycle by cycle. A re-arm input empties the recorder and starts a new recording.

Top module: `footprint_recorder`

## Requirements
- R1: After reset the recorder is armed (`frozen` = 0), holds no entries, and `scan_out` is 0.
- R2: While armed, each cycle with `rec_valid` = 1 stores the entry `{rec_tag, rec_aux}`, with the auxiliary bits in the low part. Cycles with `rec_valid` = 0 store nothing.
- R3: The buffer keeps the DEPTH most recent entries. A write into a full buffer replaces the oldest entry.
- R4: `trig_in` = 1 while armed sets `frozen` from the next cycle on. A valid entry presented in that same cycle is still stored.
- R5: While frozen, `rec_valid` and `trig_in` have no effect. The stored history and `frozen` stay unchanged until re-armed.
- R6: While frozen, each cycle with `scan_en` = 1 advances the serial output by one bit. `scan_out` shows the current bit combinationally. Entries come out from oldest to newest. Each entry comes out least significant bit first: auxiliary bit 0 first, tag MSB last.
- R7: Once every stored entry has been shifted out, `scan_out` stays 0. While armed, `scan_out` is 0 and `scan_en` has no effect.
- R8: If fewer than DEPTH entries were written, the unload returns exactly those entries, starting with the first one written.
- R9: `rearm` = 1 has priority over all other inputs. It clears `frozen`, empties the buffer and restarts the unload position. A valid entry in the re-arm cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_valid | input | 1 | Stage holds a valid instruction this cycle |
| rec_tag | input | TAG_W | In-flight tag of that instruction |
| rec_aux | input | AUX_W | Stage-specific auxiliary bits |
| trig_in | input | 1 | Early-warning trigger; freezes recording |
| rearm | input | 1 | Empties the buffer and resumes recording |
| scan_en | input | 1 | Advance the serial unload by one bit |
| scan_out | output | 1 | Current serial unload bit |
| frozen | output | 1 | Recording is stopped |

## Verification
The bench targets three kinds of fault.

- **Trigger in the same cycle as a valid write.** A design that freezes one cycle early loses the last instruction before the fault.
- **Writes and triggers that arrive after the freeze.** A design that still accepts them overwrites the history it was meant to keep.
- **Unload start point and order.** The bench wraps the buffer several times, so a design that always starts the unload at slot 0 returns the entries rotated. It also reads a partial fill and a trigger with no entries written, so a design that shifts out unwritten slots gives extra words instead of a silent `scan_out`. Bit order is checked per entry, which catches a reversed shift.

// File: rtl/fr_pkg.sv
package fr_pkg;
  // Modular increment of a ring index: (a + b) reduced once by depth.
  function automatic logic [31:0] fr_wrap(input logic [31:0] a,
                                          input logic [31:0] b,
                                          input logic [31:0] depth);
    logic [31:0] s;
    s = a + b;
    if (s >= depth) s = s - depth;
    return s;
  endfunction
endpackage

// File: rtl/fr_capture.sv
module fr_capture
  import fr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rec_valid,
  input  logic          trig_in,
  input  logic          rearm,
  output logic          we,
  output logic [PW-1:0] wr_ptr,
  output logic [CW-1:0] fill,
  output logic [PW-1:0] oldest,
  output logic          frozen
);
  logic [PW-1:0] wr_ptr_q, wr_ptr_d;
  logic [CW-1:0] fill_q, fill_d;
  logic          frozen_q, frozen_d;

  always_comb begin
    we       = rec_valid & ~frozen_q & ~rearm;
    wr_ptr_d = wr_ptr_q;
    fill_d   = fill_q;
    frozen_d = frozen_q;
    if (rearm) begin
      wr_ptr_d = '0;
      fill_d   = '0;
      frozen_d = 1'b0;
    end else if (!frozen_q) begin
      if (we) begin
        wr_ptr_d = PW'(fr_wrap(32'(wr_ptr_q), 32'd1, 32'(DEPTH)));
        if (fill_q != CW'(DEPTH)) fill_d = fill_q + 1'b1;
      end
      if (trig_in) frozen_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      fill_q   <= '0;
      frozen_q <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      fill_q   <= fill_d;
      frozen_q <= frozen_d;
    end
  end

  assign wr_ptr = wr_ptr_q;
  assign fill   = fill_q;
  assign frozen = frozen_q;
  assign oldest = (fill_q == CW'(DEPTH)) ? wr_ptr_q : '0;

  assert_trig_freezes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_in && !rearm) |=> frozen_q);
  assert_frozen_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen_q && !rearm) |=> (frozen_q && $stable(wr_ptr_q) && $stable(fill_q)));
  assert_rearm_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> (!frozen_q && fill_q == '0));
  assert_fill_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= CW'(DEPTH));
endmodule

// File: rtl/fr_store.sv
module fr_store #(
  parameter int DEPTH = 16,
  parameter int E     = 14,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [PW-1:0] wr_ptr,
  input  logic [E-1:0]  wr_data,
  input  logic [PW-1:0] rd_ptr,
  output logic [E-1:0]  rd_data
);
  logic [DEPTH*E-1:0] flat;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [E-1:0] q;
    logic         en;
    assign en = we && (wr_ptr == PW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wr_data;
    end
    assign flat[g*E +: E] = q;
  end

  assign rd_data = flat[rd_ptr*E +: E];
endmodule

// File: rtl/fr_unload.sv
module fr_unload
  import fr_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int E     = 14,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int BW = $clog2(E)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frozen,
  input  logic          rearm,
  input  logic          scan_en,
  input  logic [CW-1:0] fill,
  input  logic [PW-1:0] oldest,
  input  logic [E-1:0]  rd_word,
  output logic [PW-1:0] rd_ptr,
  output logic          scan_out
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          done, adv;

  always_comb begin
    done   = (cnt_q >= fill);
    adv    = frozen & scan_en & ~done & ~rearm;
    rd_ptr = PW'(fr_wrap(32'(oldest), 32'(cnt_q), 32'(DEPTH)));
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    if (rearm) begin
      cnt_d = '0;
      bit_d = '0;
    end else if (adv) begin
      if (bit_q == BW'(E - 1)) begin
        bit_d = '0;
        cnt_d = cnt_q + 1'b1;
      end else begin
        bit_d = bit_q + 1'b1;
      end
    end
    scan_out = (frozen && !done) ? rd_word[bit_q] : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      bit_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      bit_q <= bit_d;
    end
  end

  assert_unload_within_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= fill);
  assert_armed_no_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!frozen && !rearm) |=> $stable(cnt_q) && $stable(bit_q));
  assert_armed_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !frozen |-> !scan_out);
  assert_bit_index_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_q < BW'(E));
endmodule

// File: rtl/footprint_recorder.sv
module footprint_recorder #(
  parameter int TAG_W = 8,
  parameter int AUX_W = 6,
  parameter int DEPTH = 16,
  localparam int E  = TAG_W + AUX_W,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rec_valid,
  input  logic [TAG_W-1:0] rec_tag,
  input  logic [AUX_W-1:0] rec_aux,
  input  logic             trig_in,
  input  logic             rearm,
  input  logic             scan_en,
  output logic             scan_out,
  output logic             frozen
);
  logic          we;
  logic [PW-1:0] wr_ptr, oldest, rd_ptr;
  logic [CW-1:0] fill;
  logic [E-1:0]  rd_word;

  fr_capture #(.DEPTH(DEPTH)) u_capture (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .trig_in(trig_in),
    .rearm(rearm), .we(we), .wr_ptr(wr_ptr), .fill(fill), .oldest(oldest),
    .frozen(frozen)
  );

  fr_store #(.DEPTH(DEPTH), .E(E)) u_store (
    .clk(clk), .rst_n(rst_n), .we(we), .wr_ptr(wr_ptr),
    .wr_data({rec_tag, rec_aux}), .rd_ptr(rd_ptr), .rd_data(rd_word)
  );

  fr_unload #(.DEPTH(DEPTH), .E(E)) u_unload (
    .clk(clk), .rst_n(rst_n), .frozen(frozen), .rearm(rearm),
    .scan_en(scan_en), .fill(fill), .oldest(oldest), .rd_word(rd_word),
    .rd_ptr(rd_ptr), .scan_out(scan_out)
  );

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !frozen && !rearm) |=> fill != '0);
endmodule

// File: tb/tb_footprint_recorder.sv
module tb_footprint_recorder;
  localparam int TAG_W = 8;
  localparam int AUX_W = 6;
  localparam int DEPTH = 16;
  localparam int E     = TAG_W + AUX_W;

  logic clk, rst_n, rec_valid, trig_in, rearm, scan_en, scan_out, frozen;
  logic [TAG_W-1:0] rec_tag;
  logic [AUX_W-1:0] rec_aux;

  int checks = 0;
  int failures = 0;
  bit m_frozen = 0;
  bit finished = 0;
  logic [E-1:0] exp_q[$];

  footprint_recorder #(.TAG_W(TAG_W), .AUX_W(AUX_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_tag(rec_tag),
    .rec_aux(rec_aux), .trig_in(trig_in), .rearm(rearm), .scan_en(scan_en),
    .scan_out(scan_out), .frozen(frozen)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus; the scoreboard queue models the buffer.
  task automatic drive(input bit v, input logic [7:0] tag, input logic [5:0] aux, input bit trg);
    @(negedge clk);
    rec_valid = v; rec_tag = tag; rec_aux = aux; trig_in = trg;
    @(posedge clk);
    if (!m_frozen) begin
      if (v) begin
        if (exp_q.size() == DEPTH) void'(exp_q.pop_front());
        exp_q.push_back({tag, aux});
      end
      if (trg) m_frozen = 1;
    end
    @(negedge clk);
    rec_valid = 0; trig_in = 0;
  endtask

  task automatic do_rearm();
    @(negedge clk);
    rearm = 1; rec_valid = 1; rec_tag = 8'hEE; rec_aux = 6'h3F;
    @(posedge clk);
    @(negedge clk);
    rearm = 0; rec_valid = 0;
    exp_q.delete();
    m_frozen = 0;
  endtask

  // Monitor: shifts entries out and pops the scoreboard for each one.
  task automatic unload_all(input string req);
    logic [E-1:0] got;
    logic [E-1:0] exp;
    while (exp_q.size() > 0) begin
      exp = exp_q.pop_front();
      for (int b = 0; b < E; b++) begin
        @(negedge clk);
        got[b] = scan_out;
        scan_en = 1;
        @(posedge clk);
      end
      @(negedge clk);
      scan_en = 0;
      check(req, 32'(got), 32'(exp));
    end
    // R7: exhausted unload stays silent even with scan_en held
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R7 exhausted", 32'(scan_out), 0);
      scan_en = 1;
      @(posedge clk);
    end
    @(negedge clk);
    scan_en = 0;
  endtask

  initial begin
    rst_n = 0; rec_valid = 0; rec_tag = 0; rec_aux = 0;
    trig_in = 0; rearm = 0; scan_en = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check("R1 frozen", 32'(frozen), 0);
    check("R1 scan_out", 32'(scan_out), 0);

    // R7: scan_en while armed does nothing
    scan_en = 1; repeat (3) @(posedge clk); @(negedge clk); scan_en = 0;
    check("R7 armed", 32'(scan_out), 0);

    // R2/R8/R4: partial fill, idle gaps, trigger with a valid write
    for (int i = 0; i < 5; i++) begin
      drive(1, 8'(8'h10 + i), 6'(i * 7 + 1), 0);
      drive(0, 8'hAA, 6'h2A, 0);
    end
    drive(1, 8'hC3, 6'h15, 1);
    check("R4 frozen", 32'(frozen), 1);
    // R5: writes and triggers ignored while frozen
    drive(1, 8'h77, 6'h01, 0);
    drive(1, 8'h78, 6'h02, 1);
    check("R5 frozen held", 32'(frozen), 1);
    unload_all("R6 R8 R4 R5 entry");

    // R9: rearm discards same-cycle write and restarts
    do_rearm();
    check("R9 frozen cleared", 32'(frozen), 0);
    check("R9 scan_out", 32'(scan_out), 0);

    // R3: wrap the buffer several times, trigger on an idle cycle
    for (int i = 0; i < 2 * DEPTH + 5; i++)
      drive(1, 8'(i * 3 + 5), 6'(i), 0);
    drive(0, 8'h00, 6'h00, 1);
    check("R4 frozen idle trig", 32'(frozen), 1);
    unload_all("R3 R6 wrap entry");

    // Trigger with nothing recorded: unload is empty
    do_rearm();
    drive(0, 8'h00, 6'h00, 1);
    check("R8 empty frozen", 32'(frozen), 1);
    unload_all("R8 empty");

    // Exactly full buffer
    do_rearm();
    for (int i = 0; i < DEPTH; i++)
      drive(1, 8'(8'hF0 - i), 6'(63 - i), (i == DEPTH - 1));
    unload_all("R3 R6 full entry");

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule